// File: doc/BRIEF.md
# Serial Control-Write Echo Responder

This block sits on the device end of a four-wire serial link (SPI mode 0) and accepts register-write commands from a host. Each transaction opens with a 32-bit command word. The command word carries a command-type bit, a direction bit, a memory-map selector, a starting register address, a word count and an odd-parity bit. After the command word come one or more 32-bit data words, and then a four-byte tail that the host adds. Each complete data word becomes a single-cycle write on a register-file port. Successive words go to successive addresses.

The responder loops every received byte back on its output line, four bytes late. The host can then compare what came back with what it sent. A command word that fails parity, has the wrong type or direction bits, or names another memory map blocks every write in its frame. The loopback still runs as normal in that case. If chip select rises early, the write for any partial word is dropped and a sticky error flag is raised.

Top module: `ctlecho_resp`

## Requirements
- R1: The first four bytes after chip select falls form the command word. Bytes arrive most significant first, and bits within a byte arrive MSB first, sampled on rising SCLK.
- R2: Writes happen only when the 32-bit command word holds an odd number of ones.
- R3: Writes happen only when command-word bit 31 is 0 and bit 29 is 1.
- R4: Writes happen only when command-word bits 27:24 equal the parameter MAP_SEL (default 0).
- R5: The number of data words written equals command-word bits 7:1 plus one, which gives 1 to 128 words. The tail bytes after the last word cause no write.
- R6: Data word i (from 0) is written to address (command bits 23:8) + i, modulo 2^16. Each data word is assembled MSB first.
- R7: While chip select is low, the line out carries zero for bytes 0 to 3. For each byte k ≥ 4 it carries received byte k−4, MSB first. The output changes after falling SCLK, so it is valid at each rising SCLK.
- R8: When chip select rises before the last expected data word is complete, the partial word is not written and every earlier complete word stays written. frame_err then goes to 1 and stays at 1 until reset.
- R9: After reset, reg_wr_en, spi_miso and frame_err are all 0.
- R10: spi_miso is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from host (idle low) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Delayed loopback of received bytes |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 16 | Register write address |
| reg_wr_data | output | 32 | Register write data |
| frame_err | output | 1 | Sticky flag set by a frame that ended early |

## Verification
A wrong bit counter or a wrong loopback pointer changes the byte seen on spi_miso within one byte time. Because every byte of every frame is compared, a fault of this kind appears at the very next byte boundary. A wrong command-word latch or wrong validation logic shows up when the frame ends, as a write strobe that was not expected or a write that should have happened and did not. A wrong word counter or address counter shows up as a missing write, an extra write or a shifted address. The 128-word frame covers the case where the count field is at its maximum. The truncated frame is sent last, so the sticky flag is known to be 0 before it and can be seen to go to 1.

// File: rtl/ctlecho_pkg.sv
package ctlecho_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 32;
  localparam int WORD_B    = WORD_W / BYTE_W;
  localparam int ADDR_W    = 16;
  localparam int SEL_W     = 4;
  localparam int CNT_W     = 7;
  localparam int IDX_W     = CNT_W + 1;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_DATA = 2'd1,
    PH_TAIL = 2'd2
  } phase_e;
endpackage

// File: rtl/ctlecho_spi_rx.sv
module ctlecho_spi_rx
  import ctlecho_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              active,
  output logic              frame_start,
  output logic              frame_end,
  output logic              sclk_fall,
  output logic              at_bound,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_data
);
  localparam int BIT_W = $clog2(BYTE_W);

  logic [SYNC_STAGES-1:0] sclk_sr, cs_sr, mosi_sr;
  logic                   sclk_d, cs_d;
  logic                   sclk_s, cs_s, mosi_s, sclk_rise;
  logic [BIT_W-1:0]       bit_q, bit_n;
  logic [BYTE_W-1:0]      sh_q, sh_n;
  logic                   done_q, done_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sr <= '0;
      cs_sr   <= '1;
      mosi_sr <= '0;
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
      cs_sr   <= {cs_sr[SYNC_STAGES-2:0], cs_n};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      sclk_d  <= sclk_sr[SYNC_STAGES-1];
      cs_d    <= cs_sr[SYNC_STAGES-1];
    end
  end

  assign sclk_s      = sclk_sr[SYNC_STAGES-1];
  assign cs_s        = cs_sr[SYNC_STAGES-1];
  assign mosi_s      = mosi_sr[SYNC_STAGES-1];
  assign active      = !cs_s;
  assign frame_start = !cs_s && cs_d;
  assign frame_end   = cs_s && !cs_d;
  assign sclk_rise   = active && sclk_s && !sclk_d;
  assign sclk_fall   = active && !sclk_s && sclk_d;
  assign at_bound    = (bit_q == '0);

  always_comb begin
    bit_n  = bit_q;
    sh_n   = sh_q;
    done_n = 1'b0;
    if (frame_start) begin
      bit_n = '0;
    end else if (sclk_rise) begin
      sh_n = {sh_q[BYTE_W-2:0], mosi_s};
      if (bit_q == BIT_W'(BYTE_W - 1)) begin
        bit_n  = '0;
        done_n = 1'b1;
      end else begin
        bit_n = bit_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      sh_q   <= '0;
      done_q <= 1'b0;
    end else begin
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      done_q <= done_n;
    end
  end

  assign byte_done = done_q;
  assign byte_data = sh_q;
endmodule

// File: rtl/ctlecho_echo.sv
module ctlecho_echo
  import ctlecho_pkg::*;
#(
  parameter int DELAY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              frame_start,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              sclk_fall,
  input  logic              at_bound,
  output logic              miso
);
  logic [DELAY_BYTES-1:0][BYTE_W-1:0] line_q, line_n;
  logic [BYTE_W-1:0]                  tx_q, tx_n;

  always_comb begin
    line_n = line_q;
    tx_n   = tx_q;
    if (frame_start) begin
      line_n = '0;
      tx_n   = '0;
    end else begin
      if (byte_done) line_n = {line_q[DELAY_BYTES-2:0], byte_data};
      if (sclk_fall) tx_n = at_bound ? line_q[DELAY_BYTES-1]
                                     : {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      tx_q   <= '0;
    end else begin
      line_q <= line_n;
      tx_q   <= tx_n;
    end
  end

  assign miso = active && tx_q[BYTE_W-1];
endmodule

// File: rtl/ctlecho_cmd.sv
module ctlecho_cmd
  import ctlecho_pkg::*;
#(
  parameter logic [SEL_W-1:0] MAP_SEL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              frame_end,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              err,
  output logic [WORD_W-1:0] hdr
);
  localparam int BC_W = $clog2(WORD_B);

  phase_e            ph_q, ph_n;
  logic [WORD_W-1:0] hdr_q, hdr_n, acc_q, acc_n, wd_q, wd_n;
  logic [BC_W-1:0]   bc_q, bc_n;
  logic [IDX_W-1:0]  wi_q, wi_n, total;
  logic [ADDR_W-1:0] wa_q, wa_n;
  logic              ok_q, ok_n, any_q, any_n, err_q, err_n, we_q, we_n;

  function automatic logic hdr_ok(input logic [WORD_W-1:0] h);
    return (^h) && !h[31] && h[29] && (h[27:24] == MAP_SEL);
  endfunction

  assign total = {1'b0, hdr_q[CNT_W:1]} + 1'b1;

  always_comb begin
    ph_n  = ph_q;  hdr_n = hdr_q; acc_n = acc_q; bc_n = bc_q;
    wi_n  = wi_q;  wa_n  = wa_q;  wd_n  = wd_q;  ok_n = ok_q;
    any_n = any_q; err_n = err_q; we_n  = 1'b0;
    if (frame_start) begin
      ph_n  = PH_HDR;
      bc_n  = '0;
      wi_n  = '0;
      ok_n  = 1'b0;
      any_n = 1'b0;
    end else if (frame_end) begin
      if (any_q && ph_q != PH_TAIL) err_n = 1'b1;
      any_n = 1'b0;
      ph_n  = PH_TAIL;
    end else if (byte_done) begin
      any_n = 1'b1;
      bc_n  = bc_q + 1'b1;
      case (ph_q)
        PH_HDR: begin
          hdr_n = {hdr_q[WORD_W-BYTE_W-1:0], byte_data};
          if (bc_q == BC_W'(WORD_B - 1)) begin
            ph_n = PH_DATA;
            ok_n = hdr_ok(hdr_n);
          end
        end
        PH_DATA: begin
          acc_n = {acc_q[WORD_W-BYTE_W-1:0], byte_data};
          if (bc_q == BC_W'(WORD_B - 1)) begin
            we_n = ok_q;
            wa_n = hdr_q[23:8] + ADDR_W'(wi_q);
            wd_n = acc_n;
            wi_n = wi_q + 1'b1;
            if (wi_q == total - 1'b1) ph_n = PH_TAIL;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_HDR; hdr_q <= '0; acc_q <= '0; bc_q <= '0;
      wi_q  <= '0;     wa_q  <= '0; wd_q  <= '0; ok_q <= 1'b0;
      any_q <= 1'b0;   err_q <= 1'b0; we_q <= 1'b0;
    end else begin
      ph_q  <= ph_n;  hdr_q <= hdr_n; acc_q <= acc_n; bc_q <= bc_n;
      wi_q  <= wi_n;  wa_q  <= wa_n;  wd_q  <= wd_n;  ok_q <= ok_n;
      any_q <= any_n; err_q <= err_n; we_q  <= we_n;
    end
  end

  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign err     = err_q;
  assign hdr     = hdr_q;
endmodule

// File: rtl/ctlecho_resp.sv
module ctlecho_resp
  import ctlecho_pkg::*;
#(
  parameter logic [SEL_W-1:0] MAP_SEL     = '0,
  parameter int               DELAY_BYTES = 4,
  parameter int               SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  output logic              reg_wr_en,
  output logic [ADDR_W-1:0] reg_wr_addr,
  output logic [WORD_W-1:0] reg_wr_data,
  output logic              frame_err
);
  logic [1:0]        rst_sr;
  logic              core_rst_n;
  logic              active, frame_start, frame_end, sclk_fall, at_bound, byte_done;
  logic [BYTE_W-1:0] byte_data;
  logic [WORD_W-1:0] hdr_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sr <= '0;
    else        rst_sr <= {rst_sr[0], 1'b1};
  end
  assign core_rst_n = rst_sr[1];

  ctlecho_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(core_rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .active(active), .frame_start(frame_start),
    .frame_end(frame_end), .sclk_fall(sclk_fall), .at_bound(at_bound),
    .byte_done(byte_done), .byte_data(byte_data)
  );

  ctlecho_echo #(.DELAY_BYTES(DELAY_BYTES)) u_echo (
    .clk(clk), .rst_n(core_rst_n), .active(active),
    .frame_start(frame_start), .byte_done(byte_done), .byte_data(byte_data),
    .sclk_fall(sclk_fall), .at_bound(at_bound), .miso(spi_miso)
  );

  ctlecho_cmd #(.MAP_SEL(MAP_SEL)) u_cmd (
    .clk(clk), .rst_n(core_rst_n), .frame_start(frame_start),
    .frame_end(frame_end), .byte_done(byte_done), .byte_data(byte_data),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .err(frame_err), .hdr(hdr_word)
  );
endmodule

// File: rtl/ctlecho_resp_chk.sv
module ctlecho_resp_chk
  import ctlecho_pkg::*;
#(
  parameter logic [SEL_W-1:0] MAP_SEL = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [WORD_W-1:0] hdr,
  input logic              err
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;
  logic [IDX_W:0]    cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      last_q <= '0;
      cnt_q  <= '0;
    end else if (frame_start) begin
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_en) begin
      seen_q <= 1'b1;
      last_q <= wr_addr;
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R2
  parity_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (^hdr));
  // R3
  cmd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (!hdr[31] && hdr[29]));
  // R4
  map_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (hdr[27:24] == MAP_SEL));
  // R5
  word_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt_q < ({2'b0, hdr[CNT_W:1]} + 1'b1)));
  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && seen_q) |-> (wr_addr == last_q + 1'b1));
  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

bind ctlecho_resp ctlecho_resp_chk #(.MAP_SEL(MAP_SEL)) u_chk (
  .clk(clk), .rst_n(core_rst_n), .frame_start(frame_start),
  .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .hdr(hdr_word), .err(frame_err)
);

// File: tb/ctlecho_resp_test.sv
module ctlecho_resp_test;
  localparam int HALF = 8;
  localparam logic [31:0] STEP = 32'h0103_0507;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, wr_en, ferr;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;

  int vecs = 0, fails = 0, wr_total = 0;
  logic [15:0] log_a [0:1023];
  logic [31:0] log_d [0:1023];
  logic [7:0]  fb [0:599];

  always #2 clk = ~clk;

  ctlecho_resp uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_miso(miso), .reg_wr_en(wr_en),
    .reg_wr_addr(wr_addr), .reg_wr_data(wr_data), .frame_err(ferr)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      log_a[wr_total % 1024] = wr_addr;
      log_d[wr_total % 1024] = wr_data;
      wr_total = wr_total + 1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_hdr(input logic b31, input logic b29,
      input logic [3:0] sel, input logic [15:0] addr, input int nw);
    logic [31:0] h;
    logic [6:0]  c;
    c = 7'(nw - 1);
    h = {b31, 1'b0, b29, 1'b0, sel, addr, c, 1'b0};
    h[0] = ~^h[31:1];
    return h;
  endfunction

  task automatic spi_byte(input logic [7:0] b, input logic [7:0] exp);
    logic [7:0] rx;
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    chk("R7", "loopback byte", {24'd0, rx}, {24'd0, exp});
  endtask

  task automatic run_frame(input logic [31:0] h, input int nw, input int cut,
                           input logic [31:0] seed);
    int nb;
    logic [31:0] w;
    nb = 8 + 4 * nw - cut;
    for (int j = 0; j < 4; j++) fb[j] = h[31 - 8*j -: 8];
    for (int i = 0; i < nw; i++) begin
      w = seed + 32'(i) * STEP;
      for (int j = 0; j < 4; j++) fb[4 + 4*i + j] = w[31 - 8*j -: 8];
    end
    for (int j = 0; j < 4; j++) fb[4 + 4*nw + j] = 8'hF0 + 8'(j);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 0; k < nb; k++)
      spi_byte(fb[k], (k < 4) ? 8'h00 : fb[k - 4]);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
    chk("R10", "miso idle", {31'd0, miso}, 32'd0);
  endtask

  task automatic expect_writes(input string req, input int base, input int n,
                               input logic [15:0] addr, input logic [31:0] seed);
    chk(req, "write count", 32'(wr_total - base), 32'(n));
    for (int i = 0; i < n && i < wr_total - base; i++) begin
      chk("R6", "write addr", {16'd0, log_a[(base + i) % 1024]}, {16'd0, 16'(addr + 16'(i))});
      chk("R6", "write data", log_d[(base + i) % 1024], seed + 32'(i) * STEP);
    end
  endtask

  task automatic t_reset();
    chk("R9", "wr_en after reset", {31'd0, wr_en}, 32'd0);
    chk("R9", "miso after reset", {31'd0, miso}, 32'd0);
    chk("R9", "frame_err after reset", {31'd0, ferr}, 32'd0);
    sclk = 1'b1; repeat (HALF) @(negedge clk); sclk = 1'b0; repeat (HALF) @(negedge clk);
    chk("R10", "miso with cs high", {31'd0, miso}, 32'd0);
    chk("R9", "no write from idle clocking", 32'(wr_total), 32'd0);
  endtask

  task automatic t_single();
    int b = wr_total;
    run_frame(mk_hdr(1'b0, 1'b1, 4'h0, 16'h0040, 1), 1, 0, 32'hDEAD_BEEF);
    expect_writes("R1", b, 1, 16'h0040, 32'hDEAD_BEEF);
  endtask

  task automatic t_burst();
    int b = wr_total;
    run_frame(mk_hdr(1'b0, 1'b1, 4'h0, 16'hFFFE, 5), 5, 0, 32'h1234_5678);
    expect_writes("R5", b, 5, 16'hFFFE, 32'h1234_5678);
  endtask

  task automatic t_max();
    int b = wr_total;
    run_frame(mk_hdr(1'b0, 1'b1, 4'h0, 16'h0100, 128), 128, 0, 32'h0BAD_F00D);
    expect_writes("R5", b, 128, 16'h0100, 32'h0BAD_F00D);
  endtask

  task automatic t_parity();
    int b = wr_total;
    logic [31:0] h;
    h = mk_hdr(1'b0, 1'b1, 4'h0, 16'h0200, 2);
    h[0] = ~h[0];
    run_frame(h, 2, 0, 32'hAAAA_5555);
    chk("R2", "writes with even parity", 32'(wr_total - b), 32'd0);
  endtask

  task automatic t_cmd();
    int b = wr_total;
    run_frame(mk_hdr(1'b1, 1'b1, 4'h0, 16'h0300, 1), 1, 0, 32'h1111_2222);
    chk("R3", "writes with bit31 set", 32'(wr_total - b), 32'd0);
    b = wr_total;
    run_frame(mk_hdr(1'b0, 1'b0, 4'h0, 16'h0300, 1), 1, 0, 32'h3333_4444);
    chk("R3", "writes with bit29 clear", 32'(wr_total - b), 32'd0);
  endtask

  task automatic t_map();
    int b = wr_total;
    run_frame(mk_hdr(1'b0, 1'b1, 4'h1, 16'h0400, 2), 2, 0, 32'h5555_6666);
    chk("R4", "writes to other map", 32'(wr_total - b), 32'd0);
    chk("R8", "no error on full frames", {31'd0, ferr}, 32'd0);
  endtask

  task automatic t_trunc();
    int b = wr_total;
    run_frame(mk_hdr(1'b0, 1'b1, 4'h0, 16'h0500, 3), 3, 10, 32'h7777_8888);
    expect_writes("R8", b, 1, 16'h0500, 32'h7777_8888);
    chk("R8", "error flag after early end", {31'd0, ferr}, 32'd1);
    run_frame(mk_hdr(1'b0, 1'b1, 4'h0, 16'h0600, 1), 1, 0, 32'h9999_0000);
    chk("R8", "error flag stays set", {31'd0, ferr}, 32'd1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_single();
    t_burst();
    t_parity();
    t_cmd();
    t_map();
    t_max();
    t_trunc();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule